// File: doc/BRIEF.md
# Manual and Undervoltage Reset Generator

This block drives the system reset of a synchronous design from two causes: an undervoltage flag from an external supply comparator, and an active-low manual reset line that may come straight from a bouncing push button. While either cause is present the reset is held. Once both causes are gone, the reset is held for a further fixed stretch before it releases. If a cause returns before that, the stretch starts again.

Both inputs pass through a two-flop synchroniser. The manual line is then debounced by a counter, so a short glitch or contact bounce never starts a reset. The block comes out of power-on with reset asserted and the stretch count at zero, so the first release follows one full stretch. The reset is presented in both polarities. A watchdog can reset the system only if its output is wired, outside the block, to the manual input.

Top module: `reset_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_n` is 0. With no cause present, `rst_n` rises exactly `STRETCH_CYC` clock edges after `por_n` rises.
- R2: `undervolt` asserts reset at the third rising edge after it goes high. Reset stays asserted for as long as `undervolt` stays high.
- R3: With the manual line idle, `rst_n` rises at the (`STRETCH_CYC`+2)th edge after `undervolt` falls, and not before.
- R4: Holding `mr_btn_n` low (0 = pressed) for at least `DEBOUNCE_CYC` cycles asserts reset at the (`DEBOUNCE_CYC`+3)th edge after the press, and not before.
- R5: A low pulse on `mr_btn_n` shorter than `DEBOUNCE_CYC` cycles has no effect on the outputs. The same holds for bounce that never stays at one level for `DEBOUNCE_CYC` cycles.
- R6: After the manual line returns high (released), `rst_n` rises at the (`DEBOUNCE_CYC`+2+`STRETCH_CYC`)th edge.
- R7: A cause that reappears while the stretch is running restarts the stretch. The release time is then counted from the last time the cause clears.
- R8: `rst` is always the inverse of `rst_n`.
- R9: When both causes overlap, the stretch is counted from whichever cause clears last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mr_btn_n | input | 1 | Manual reset request, active low, may bounce |
| undervolt | input | 1 | High while the supply is below its threshold |
| rst_n | output | 1 | System reset, active low |
| rst | output | 1 | System reset, active high |

## Verification
A debounce counter that never clears would let slow bounce through as a press. That shows up as `rst_n` falling a few cycles after a short pulse. A stretch counter that misses a restart, or that is off by one, moves the rising edge of `rst_n` by one or more cycles. The bench therefore measures every release to the exact edge instead of only checking the final level. A fault in the polarity pair would show on the very next cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef struct packed {
        logic uv;
        logic mr_n;
    } sup_in_t;

    localparam sup_in_t SUP_IN_IDLE = '{uv: 1'b0, mr_n: 1'b1};
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned       STAGES  = sup_pkg::SYNC_DEPTH,
    parameter sup_pkg::sup_in_t  RST_VAL = sup_pkg::SUP_IN_IDLE
) (
    input  logic             clk,
    input  logic             por_n,
    input  sup_pkg::sup_in_t din,
    output sup_pkg::sup_in_t dout
);
    sup_pkg::sup_in_t stage_d [STAGES];
    sup_pkg::sup_in_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int unsigned DEBOUNCE_CYC = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic level_in,
    output logic level_out
);
    localparam int unsigned DW = (DEBOUNCE_CYC < 2) ? 1 : $clog2(DEBOUNCE_CYC);

    typedef struct packed {
        logic          level;
        logic [DW-1:0] cnt;
    } db_t;

    db_t db_d, db_q;

    always_comb begin
        db_d = db_q;
        if (level_in == db_q.level) begin
            db_d.cnt = '0;
        end else if (db_q.cnt == DW'(DEBOUNCE_CYC - 1)) begin
            db_d.level = level_in;
            db_d.cnt   = '0;
        end else begin
            db_d.cnt = db_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            db_q <= '{level: 1'b1, cnt: '0};
        end else begin
            db_q <= db_d;
        end
    end

    assign level_out = db_q.level;
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
    parameter int unsigned STRETCH_CYC = 20
) (
    input  logic clk,
    input  logic por_n,
    input  logic cause,
    output logic active
);
    localparam int unsigned CW = (STRETCH_CYC < 2) ? 1 : $clog2(STRETCH_CYC);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cause) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == CW'(STRETCH_CYC - 1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
    parameter int unsigned STRETCH_CYC  = 200,
    parameter int unsigned DEBOUNCE_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic mr_btn_n,
    input  logic undervolt,
    output logic rst_n,
    output logic rst
);
    sup_pkg::sup_in_t raw_in;
    sup_pkg::sup_in_t sync_in;
    logic             uv_sync;
    logic             mr_stable;
    logic             cause;
    logic             hold_active;

    assign raw_in = '{uv: undervolt, mr_n: mr_btn_n};

    sup_sync #(
        .STAGES  (sup_pkg::SYNC_DEPTH),
        .RST_VAL (sup_pkg::SUP_IN_IDLE)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (raw_in),
        .dout  (sync_in)
    );

    assign uv_sync = sync_in.uv;

    sup_debounce #(
        .DEBOUNCE_CYC (DEBOUNCE_CYC)
    ) u_debounce (
        .clk       (clk),
        .por_n     (por_n),
        .level_in  (sync_in.mr_n),
        .level_out (mr_stable)
    );

    assign cause = uv_sync | ~mr_stable;

    sup_stretch #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_stretch (
        .clk    (clk),
        .por_n  (por_n),
        .cause  (cause),
        .active (hold_active)
    );

    assign rst   = hold_active;
    assign rst_n = ~hold_active;
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk (
    input logic clk,
    input logic por_n,
    input logic undervolt,
    input logic rst_n,
    input logic rst,
    input logic uv_sync,
    input logic mr_stable
);
    logic [1:0] uv_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            uv_run <= '0;
        end else if (!undervolt) begin
            uv_run <= '0;
        end else if (uv_run != 2'd3) begin
            uv_run <= uv_run + 2'd1;
        end
    end

    // R8: the two polarities always disagree
    p_complement_r8: assert property (@(posedge clk) disable iff (!por_n)
        rst == !rst_n);

    // R2: three sampled edges of undervolt force reset
    p_uv_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        (uv_run == 2'd3) |-> !rst_n);

    // R5/R4: reset only asserts when a filtered cause was present
    p_cause_needed_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_n) |-> $past(uv_sync || !mr_stable));

    // R3: release only after a quiet run of filtered causes
    p_release_quiet_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> ($past(!uv_sync && mr_stable) && $past(!uv_sync && mr_stable, 2)));
endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .undervolt (undervolt),
    .rst_n     (rst_n),
    .rst       (rst),
    .uv_sync   (uv_sync),
    .mr_stable (mr_stable)
);

// File: tb/reset_supervisor_bench.sv
module reset_supervisor_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned S = 20;
    localparam int unsigned D = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic mr_btn_n = 1'b1;
    logic undervolt = 1'b0;
    logic rst_n;
    logic rst;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_supervisor #(.STRETCH_CYC(S), .DEBOUNCE_CYC(D)) u_reset_supervisor (
        .clk(clk), .por_n(por_n), .mr_btn_n(mr_btn_n), .undervolt(undervolt),
        .rst_n(rst_n), .rst(rst)
    );

    typedef struct packed {
        logic       uv;
        logic       mr_n;
        logic [7:0] hold;
        logic       exp_n;
        logic [3:0] req;
    } vec_t;

    // Applied at a falling edge, held for 'hold' cycles, then rst_n compared.
    localparam vec_t VEC [11] = '{
        '{1'b0, 1'b1, 8'd4,  1'b1, 4'd1},  // R1 idle stays released
        '{1'b1, 1'b1, 8'd3,  1'b0, 4'd2},  // R2 asserted at third edge
        '{1'b1, 1'b1, 8'd30, 1'b0, 4'd2},  // R2 held while low supply
        '{1'b0, 1'b1, 8'd21, 1'b0, 4'd3},  // R3 still held one cycle early
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd3},  // R3 released at S+2
        '{1'b0, 1'b0, 8'd6,  1'b1, 4'd4},  // R4 not yet at D+2
        '{1'b0, 1'b0, 8'd1,  1'b0, 4'd4},  // R4 asserted at D+3
        '{1'b0, 1'b1, 8'd25, 1'b0, 4'd6},  // R6 held one cycle early
        '{1'b0, 1'b1, 8'd1,  1'b1, 4'd6},  // R6 released at D+2+S
        '{1'b0, 1'b0, 8'd3,  1'b1, 4'd5},  // R5 short press
        '{1'b0, 1'b1, 8'd10, 1'b1, 4'd5}   // R5 short press left no trace
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_n(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts falling edges until rst_n is seen high
    task automatic measure(output int n);
        n = 0;
        while (rst_n !== 1'b1 && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        tick(3);
        check("R1", rst_n, 1'b0);
        check("R8", rst, 1'b1);
        por_n = 1'b1;
        measure(n);
        check_n("R1", n, S);

        for (int i = 0; i < 11; i++) begin
            undervolt = VEC[i].uv;
            mr_btn_n  = VEC[i].mr_n;
            tick(int'(VEC[i].hold));
            check($sformatf("R%0d vec%0d", VEC[i].req, i), rst_n, VEC[i].exp_n);
            check("R8", rst, ~rst_n);
        end

        // R7: supply dips again during the stretch
        undervolt = 1'b1; tick(5);
        undervolt = 1'b0; tick(10);
        check("R7", rst_n, 1'b0);
        undervolt = 1'b1; tick(2);
        undervolt = 1'b0;
        measure(n);
        check_n("R7", n, S + 2);

        // R9: overlapping causes, manual clears last
        undervolt = 1'b1; mr_btn_n = 1'b0; tick(10);
        undervolt = 1'b0; tick(30);
        check("R9", rst_n, 1'b0);
        check("R8", rst, 1'b1);
        mr_btn_n = 1'b1;
        measure(n);
        check_n("R9", n, D + 2 + S);

        // R5: contact bounce toggling every cycle
        for (int k = 0; k < 20; k++) begin
            mr_btn_n = ~mr_btn_n;
            tick(1);
            if (rst_n !== 1'b1) check("R5 bounce", rst_n, 1'b1);
        end
        mr_btn_n = 1'b1;
        tick(D + 4);
        check("R5", rst_n, 1'b1);
        check("R8", rst, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule